// File: doc/BRIEF.md
# Standby Power Sequencer with Watchdog

This block sequences the main power rail of an appliance front panel. Two outputs control the rail. `stby_o` asks the supply board to turn the main power off, and `mute_o` silences the audio path. The block drives both from three things: the level of a host health input, a wake pulse raised when a programmed hot key is matched, and a watchdog that counts seconds from an external one-per-second strobe.

After power-on reset the block turns main power on and waits for the host to report that it is ready. A watchdog with a fixed default limit guards this wait. When the host comes up, the watchdog stops, unless the host has asked for it to keep running. Once the host has been up for a full second, the audio is released.

The system goes back to standby in three cases: the host withdraws its ready level, the boot guard expires, or the kept watchdog expires. When the audio is live, the block always mutes it at least one second strobe before it raises the standby request. A sticky flag records that a watchdog expiry caused the return, and the host clears it with a pulse.

Top module: `stby_sequencer`

## Requirements
- R1: While reset is held and directly after it, `stby_o` is 0 (main power on), `mute_o` is 1 and `wdt_flag_o` is 0.
- R2: After reset the watchdog limit is DEF_TMO seconds (10), whatever the value on `wdt_tmo_i`. With `ready_i` held low, `stby_o` rises on the clock edge that samples the tenth `tick_i` pulse and not earlier.
- R3: When `ready_i` is high and `wdt_keep_i` is low, the watchdog does not count, and `stby_o` stays low for any number of ticks.
- R4: After the host becomes ready, `mute_o` falls on the edge that samples the second `tick_i` pulse seen with `ready_i` continuously high. Until then it stays high.
- R5: If `ready_i` falls while the host is up, `mute_o` is high from the next edge. `stby_o` stays low until the edge that samples the next `tick_i` pulse, and rises there.
- R6: In standby, a `wake_i` pulse drops `stby_o` on the next edge and arms the watchdog with the limit on `wdt_tmo_i` (1 to 15). With `ready_i` low, `stby_o` rises again on the edge of that many-th tick.
- R7: A wake taken with `wdt_tmo_i` equal to 0 (never programmed) uses the 10-second default limit.
- R8: A `wdt_kick_i` pulse restarts the watchdog count from zero.
- R9: With `wdt_keep_i` high, the watchdog also counts while the host is ready. On expiry the block mutes, and it enters standby on the next tick.
- R10: In standby, ticks do not count and `ready_i` has no effect. A `wake_i` pulse outside standby is ignored and does not restart the count.
- R11: `wdt_flag_o` rises when a watchdog expiry starts a return to standby, does not rise when the return is caused by `ready_i` falling, and is cleared by `flag_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| ready_i | input | 1 | Host health level, high when the host runs normally |
| wake_i | input | 1 | One-cycle hot-key match pulse |
| wdt_kick_i | input | 1 | One-cycle watchdog restart pulse |
| wdt_keep_i | input | 1 | Keep the watchdog counting while the host is ready |
| wdt_tmo_i | input | TMO_W | Watchdog limit in seconds taken at wake; 0 selects the default |
| flag_clr_i | input | 1 | One-cycle clear of the expiry flag |
| stby_o | output | 1 | High requests main power off |
| mute_o | output | 1 | High mutes audio |
| wdt_flag_o | output | 1 | Last return to standby was caused by watchdog expiry |

## Verification
The bench builds the block with its defaults: a 4-bit limit field and a 10-second default. It drives the second strobe directly as single-cycle pulses, so full boot-guard expiries and programmed limits cost only a handful of cycles each. This brings exact boundary checks within reach: the ninth tick against the tenth, the limit picked when the wake input is 0, and a restart in the middle of the count. Long runs of ticks in standby and in the ready state show that neither state counts.

// File: rtl/stby_sequencer.sv
module stby_sequencer #(
  parameter int               TMO_W   = 4,
  parameter logic [TMO_W-1:0] DEF_TMO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ready_i,
  input  logic             wake_i,
  input  logic             wdt_kick_i,
  input  logic             wdt_keep_i,
  input  logic [TMO_W-1:0] wdt_tmo_i,
  input  logic             flag_clr_i,
  output logic             stby_o,
  output logic             mute_o,
  output logic             wdt_flag_o
);

  typedef enum logic [1:0] {S_BOOT, S_RUN, S_MUTE, S_STBY} st_t;

  st_t              state;
  logic [TMO_W-1:0] cnt, limit;
  logic [TMO_W:0]   cnt_nx;
  logic [1:0]       up_ticks;
  logic             cnt_en, expire;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign cnt_en = (state == S_BOOT && !ready_i) ||
                  (state == S_RUN && ready_i && wdt_keep_i);
  assign expire = cnt_en && tick_i && !wdt_kick_i && (cnt_nx >= {1'b0, limit});

  assign stby_o = (state == S_STBY);
  assign mute_o = !(state == S_RUN && up_ticks == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_BOOT;
      cnt        <= '0;
      limit      <= DEF_TMO;
      up_ticks   <= '0;
      wdt_flag_o <= 1'b0;
    end else begin
      if (expire)          wdt_flag_o <= 1'b1;
      else if (flag_clr_i) wdt_flag_o <= 1'b0;

      if (wdt_kick_i)               cnt <= '0;
      else if (cnt_en && tick_i)    cnt <= cnt_nx[TMO_W-1:0];

      unique case (state)
        S_BOOT: begin
          if (ready_i) begin
            state    <= S_RUN;
            cnt      <= '0;
            up_ticks <= '0;
          end else if (expire) begin
            state <= S_STBY;
          end
        end
        S_RUN: begin
          if (!ready_i || expire) state <= S_MUTE;
          else if (tick_i && up_ticks != 2'd2) up_ticks <= up_ticks + 2'd1;
        end
        S_MUTE: begin
          if (tick_i) state <= S_STBY;
        end
        S_STBY: begin
          if (wake_i) begin
            state <= S_BOOT;
            cnt   <= '0;
            limit <= (wdt_tmo_i == '0) ? DEF_TMO : wdt_tmo_i;
          end
        end
        default: state <= S_BOOT;
      endcase
    end
  end

endmodule

// File: rtl/stby_sequencer_chk.sv
module stby_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic ready_i,
  input logic wake_i,
  input logic stby_o,
  input logic mute_o,
  input logic wdt_flag_o
);

  a_r5_mute_before_stby: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_o) |-> $past(mute_o) && $past(tick_i));

  a_r6_leave_only_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_o) |-> $past(wake_i));

  a_r10_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stby_o && !wake_i |=> stby_o);

  a_r4_unmute_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> $past(ready_i) && !stby_o);

  a_r11_flag_muted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_flag_o) |-> mute_o);

endmodule

bind stby_sequencer stby_sequencer_chk chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ready_i(ready_i), .wake_i(wake_i),
  .stby_o(stby_o), .mute_o(mute_o), .wdt_flag_o(wdt_flag_o)
);

// File: tb/stby_sequencer_test.sv
module stby_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {ready,tick,wake,kick} tmo {stby,mute,flag} req
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b1000, 4'd0, 3'b010, 5'd3},   // R3 host ready
    {4'b1100, 4'd0, 3'b010, 5'd4},   // R4 first tick
    {4'b1000, 4'd0, 3'b010, 5'd4},
    {4'b1100, 4'd0, 3'b000, 5'd4},   // R4 unmute
    {4'b0000, 4'd0, 3'b010, 5'd5},   // R5 mute first
    {4'b0000, 4'd0, 3'b010, 5'd5},
    {4'b0100, 4'd0, 3'b110, 5'd5},   // R5 standby on tick
    {4'b0100, 4'd0, 3'b110, 5'd10},  // R10
    {4'b1000, 4'd0, 3'b110, 5'd10},  // R10 ready ignored
    {4'b0010, 4'd3, 3'b010, 5'd6},   // R6 wake
    {4'b0100, 4'd3, 3'b010, 5'd6},
    {4'b0100, 4'd3, 3'b010, 5'd6},
    {4'b0100, 4'd3, 3'b111, 5'd6}    // R6 expiry
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, ready = 0, wake = 0, kick = 0, keep = 0, fclr = 0;
  logic [3:0] tmo = '0;
  logic stby, mute, flag;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_sequencer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ready_i(ready), .wake_i(wake),
    .wdt_kick_i(kick), .wdt_keep_i(keep), .wdt_tmo_i(tmo), .flag_clr_i(fclr),
    .stby_o(stby), .mute_o(mute), .wdt_flag_o(flag)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    tick = 0; wake = 0; kick = 0; fclr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(stby, 1'b0, "R1", "stby in reset");
    chk(mute, 1'b1, "R1", "mute in reset");
    rst_n = 1;
    @(negedge clk);
    chk(flag, 1'b0, "R1", "flag after reset");

    for (int v = 0; v < NVEC; v++) begin
      {ready, tick, wake, kick} = VEC[v][15:12];
      tmo = VEC[v][11:8];
      cyc();
      chk(stby, VEC[v][7], $sformatf("R%0d", VEC[v][4:0]), $sformatf("vec %0d stby", v));
      chk(mute, VEC[v][6], $sformatf("R%0d", VEC[v][4:0]), $sformatf("vec %0d mute", v));
      chk(flag, VEC[v][5], $sformatf("R%0d", VEC[v][4:0]), $sformatf("vec %0d flag", v));
    end

    // R2: default boot limit, input value ignored
    rst_n = 0; ready = 0; tmo = 4'd5; @(negedge clk); rst_n = 1; @(negedge clk);
    ticks(9);
    chk(stby, 1'b0, "R2", "stby after 9 ticks");
    ticks(1);
    chk(stby, 1'b1, "R2", "stby after 10 ticks");
    chk(flag, 1'b1, "R11", "flag on boot expiry");

    // R11 clear
    fclr = 1; cyc();
    chk(flag, 1'b0, "R11", "flag cleared");

    // R7: zero limit selects default
    tmo = 4'd0; wake = 1; cyc();
    chk(stby, 1'b0, "R7", "woken");
    ticks(9);
    chk(stby, 1'b0, "R7", "stby after 9 ticks");
    ticks(1);
    chk(stby, 1'b1, "R7", "stby after 10 ticks");

    // R10: no counting in standby, wake outside standby ignored
    ticks(20);
    chk(stby, 1'b1, "R10", "standby held over ticks");
    tmo = 4'd4; wake = 1; cyc();
    ticks(2);
    tmo = 4'd15; wake = 1; cyc();
    ticks(1);
    chk(stby, 1'b0, "R10", "third tick");
    ticks(1);
    chk(stby, 1'b1, "R10", "fourth tick despite late wake");

    // R8: kick restarts count
    tmo = 4'd4; wake = 1; cyc();
    ticks(3);
    kick = 1; cyc();
    ticks(3);
    chk(stby, 1'b0, "R8", "after kick and 3 ticks");
    ticks(1);
    chk(stby, 1'b1, "R8", "after kick and 4 ticks");
    fclr = 1; cyc();

    // R3: ready stops watchdog; R11 no flag on ready loss
    tmo = 4'd2; wake = 1; cyc();
    ready = 1; cyc();
    ticks(20);
    chk(stby, 1'b0, "R3", "stby while ready");
    chk(mute, 1'b0, "R3", "mute released while ready");
    ready = 0; cyc();
    ticks(1);
    chk(stby, 1'b1, "R5", "standby after ready loss");
    chk(flag, 1'b0, "R11", "no flag on ready loss");

    // R9: watchdog kept running while ready
    tmo = 4'd2; keep = 1; wake = 1; cyc();
    ready = 1; cyc();
    ticks(1);
    chk(stby, 1'b0, "R9", "one tick");
    ticks(1);
    chk(mute, 1'b1, "R9", "muted on expiry");
    chk(stby, 1'b0, "R9", "not yet standby");
    chk(flag, 1'b1, "R11", "flag on kept expiry");
    ticks(1);
    chk(stby, 1'b1, "R9", "standby on next tick");
    keep = 0; ready = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule